// File: doc/BRIEF.md
# Byte-to-Dword Boot Fetch Bridge

This block connects a 32-bit host code-fetch port to an 8-bit boot ROM. Each host request starts a burst of eight dword transfers. The bridge gets each dword by issuing four single-byte ROM reads at consecutive byte addresses. It packs the four bytes into a word, lowest address in the least significant byte, and then pulses a ready strobe for that word. The strobe of the eighth word also carries a burst-done flag. The consumer waits for this flag before it treats the fetched code as usable.

The address space is 20 bits and wraps at the top. The first burst after reset starts at the reset vector 0xFFFF0, whatever the host puts on the address port. Later bursts start at the host address, with its two low bits cleared. Only dwords in the boot region 0xE0000 to 0xFFFFF read the ROM. A dword outside that region returns all-ones data with an error flag and makes no ROM access.

The ROM has a fixed read latency. The bridge counts this latency itself and keeps only one byte read in flight at a time.

Top module: `boot_fetch_bridge`

## Requirements
- R1: While reset is asserted and just after it is released, `ready_o`, `burst_done_o`, `rom_rd_o` and `err_o` are 0 and `data_o` is 0.
- R2: The first burst accepted after reset uses base address 0xFFFF0 and ignores `addr_i`. Every later burst uses `addr_i` with bits 1:0 forced to 0.
- R3: For each dword whose address is in the boot region, exactly four one-cycle `rom_rd_o` strobes are issued, at byte addresses d, d+1, d+2 and d+3 in that order. These are followed by one single-cycle `ready_o` pulse.
- R4: The packed word puts the byte read from d at bits 7:0, d+1 at bits 15:8, d+2 at bits 23:16 and d+3 at bits 31:24.
- R5: `rom_data_i` is sampled on the ROM_LAT-th rising edge (default 2) after the edge that samples the read strobe. Only one read is outstanding at a time, so in-dword strobes are ROM_LAT+1 cycles apart.
- R6: A burst is eight dwords at addresses base, base+4, … base+28. `burst_done_o` is high only during the eighth `ready_o` pulse.
- R7: The boot region is 0xE0000 to 0xFFFFF inclusive. A dword outside it produces no ROM strobe and completes with `data_o` = 0xFFFFFFFF and `err_o` = 1. A dword inside it completes with `err_o` = 0.
- R8: Dword addresses advance modulo 2^20, so the dword after 0xFFFFC is 0x00000.
- R9: `req_i` is ignored while a burst is in progress: the running burst is unchanged and no extra burst follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Burst request, taken when the bridge is idle |
| addr_i | input | 20 | Burst start byte address |
| ready_o | output | 1 | One-cycle strobe: `data_o` holds a completed dword |
| data_o | output | 32 | Packed dword |
| err_o | output | 1 | Dword lay outside the boot region |
| burst_done_o | output | 1 | High with the last ready strobe of a burst |
| rom_rd_o | output | 1 | One-cycle ROM byte read strobe |
| rom_addr_o | output | 20 | ROM byte address |
| rom_data_i | input | 8 | ROM read data, valid ROM_LAT cycles after the strobe |

## Verification
The bench builds the bridge with its default parameters: 20-bit addresses, a 32-bit host word over an 8-bit ROM, eight-dword bursts and a two-cycle ROM latency. With these values the reset-vector burst itself crosses the top of the address space. Its last four dwords wrap to 0x00000 and fall outside the boot region, so wrap and the error fill are both observed at the ports. The ROM model returns data only in the single cycle the latency allows, so a capture on the wrong edge shows up as a data mismatch. Bursts that start just below the region and at unaligned addresses cover the region boundary and the alignment rule.

// File: rtl/bfb_pkg.sv
package bfb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_RD,
    ST_WAIT,
    ST_RESP
  } bfb_state_e;
endpackage

// File: rtl/bfb_addr_gen.sv
module bfb_addr_gen #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned BYTES     = 4,
  parameter int unsigned BURST_LEN = 8,
  parameter logic [ADDR_W-1:0] RESET_VEC = 20'hFFFF0,
  parameter logic [ADDR_W-1:0] REGION_LO = 20'hE0000,
  parameter logic [ADDR_W-1:0] REGION_HI = 20'hFFFFF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic                     dword_adv_i,
  input  logic                     byte_adv_i,
  output logic [ADDR_W-1:0]        byte_addr_o,
  output logic [$clog2(BYTES)-1:0] lane_o,
  output logic                     in_region_o,
  output logic                     last_byte_o,
  output logic                     last_dword_o
);
  localparam int unsigned OFF_W = $clog2(BYTES);
  localparam int unsigned CNT_W = $clog2(BURST_LEN);

  logic              first_q;
  logic [ADDR_W-1:0] dw_addr_q;
  logic [CNT_W-1:0]  dw_cnt_q;
  logic [OFF_W-1:0]  byte_cnt_q;
  logic [ADDR_W-1:0] start_addr;

  assign start_addr = first_q ? {RESET_VEC[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                              : {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q    <= 1'b1;
      dw_addr_q  <= '0;
      dw_cnt_q   <= '0;
      byte_cnt_q <= '0;
    end else if (start_i) begin
      first_q    <= 1'b0;
      dw_addr_q  <= start_addr;
      dw_cnt_q   <= '0;
      byte_cnt_q <= '0;
    end else if (dword_adv_i) begin
      // modulo 2^ADDR_W by width
      dw_addr_q  <= dw_addr_q + ADDR_W'(BYTES);
      dw_cnt_q   <= dw_cnt_q + 1'b1;
      byte_cnt_q <= '0;
    end else if (byte_adv_i) begin
      byte_cnt_q <= byte_cnt_q + 1'b1;
    end
  end

  assign byte_addr_o  = {dw_addr_q[ADDR_W-1:OFF_W], byte_cnt_q};
  assign lane_o       = byte_cnt_q;
  assign in_region_o  = ({1'b0, dw_addr_q} >= {1'b0, REGION_LO}) &&
                        ({1'b0, dw_addr_q} <= {1'b0, REGION_HI});
  assign last_byte_o  = (byte_cnt_q == OFF_W'(BYTES - 1));
  assign last_dword_o = (dw_cnt_q == CNT_W'(BURST_LEN - 1));
endmodule

// File: rtl/bfb_byte_packer.sv
module bfb_byte_packer #(
  parameter int unsigned ROM_W = 8,
  parameter int unsigned BYTES = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cap_i,
  input  logic                     fill_i,
  input  logic [$clog2(BYTES)-1:0] lane_i,
  input  logic [ROM_W-1:0]         byte_i,
  output logic [BYTES*ROM_W-1:0]   word_o
);
  localparam int unsigned OFF_W = $clog2(BYTES);

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [ROM_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             lane_q <= '0;
      else if (fill_i)                         lane_q <= '1;
      else if (cap_i && lane_i == OFF_W'(g))   lane_q <= byte_i;
    end
    assign word_o[g*ROM_W +: ROM_W] = lane_q;
  end
endmodule

// File: rtl/bfb_seq.sv
module bfb_seq
  import bfb_pkg::*;
#(
  parameter int unsigned ROM_LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic in_region_i,
  input  logic last_byte_i,
  input  logic last_dword_i,
  output logic start_o,
  output logic rd_o,
  output logic cap_o,
  output logic byte_adv_o,
  output logic dword_adv_o,
  output logic fill_o,
  output logic ready_o,
  output logic done_o,
  output logic err_o
);
  localparam int unsigned LAT_W = $clog2(ROM_LAT + 1);

  bfb_state_e       state_q, state_d;
  logic [LAT_W-1:0] lat_q;
  logic             err_q;
  logic             lat_hit;

  assign lat_hit = (lat_q == LAT_W'(ROM_LAT - 1));

  always_comb begin
    state_d     = state_q;
    start_o     = 1'b0;
    rd_o        = 1'b0;
    cap_o       = 1'b0;
    byte_adv_o  = 1'b0;
    dword_adv_o = 1'b0;
    fill_o      = 1'b0;
    ready_o     = 1'b0;
    done_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        start_o = 1'b1;
        state_d = ST_CHK;
      end
      ST_CHK: begin
        if (in_region_i) state_d = ST_RD;
        else begin
          fill_o  = 1'b1;
          state_d = ST_RESP;
        end
      end
      ST_RD: begin
        rd_o    = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: if (lat_hit) begin
        cap_o = 1'b1;
        if (last_byte_i) state_d = ST_RESP;
        else begin
          byte_adv_o = 1'b1;
          state_d    = ST_RD;
        end
      end
      ST_RESP: begin
        ready_o = 1'b1;
        done_o  = last_dword_i;
        if (last_dword_i) state_d = ST_IDLE;
        else begin
          dword_adv_o = 1'b1;
          state_d     = ST_CHK;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lat_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RD)                  lat_q <= '0;
      else if (state_q == ST_WAIT && !lat_hit) lat_q <= lat_q + 1'b1;
      if (state_q == ST_CHK)                 err_q <= !in_region_i;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/boot_fetch_bridge.sv
module boot_fetch_bridge #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned HOST_W    = 32,
  parameter int unsigned ROM_W     = 8,
  parameter int unsigned BURST_LEN = 8,
  parameter int unsigned ROM_LAT   = 2,
  parameter logic [ADDR_W-1:0] RESET_VEC = 20'hFFFF0,
  parameter logic [ADDR_W-1:0] REGION_LO = 20'hE0000,
  parameter logic [ADDR_W-1:0] REGION_HI = 20'hFFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ready_o,
  output logic [HOST_W-1:0] data_o,
  output logic              err_o,
  output logic              burst_done_o,
  output logic              rom_rd_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  input  logic [ROM_W-1:0]  rom_data_i
);
  localparam int unsigned BYTES = HOST_W / ROM_W;
  localparam int unsigned OFF_W = $clog2(BYTES);

  logic             start, cap, byte_adv, dword_adv, fill;
  logic             in_region, last_byte, last_dword;
  logic [OFF_W-1:0] lane;

  bfb_addr_gen #(
    .ADDR_W(ADDR_W), .BYTES(BYTES), .BURST_LEN(BURST_LEN),
    .RESET_VEC(RESET_VEC), .REGION_LO(REGION_LO), .REGION_HI(REGION_HI)
  ) i_addr_gen (
    .clk_i, .rst_ni,
    .start_i      (start),
    .req_addr_i   (addr_i),
    .dword_adv_i  (dword_adv),
    .byte_adv_i   (byte_adv),
    .byte_addr_o  (rom_addr_o),
    .lane_o       (lane),
    .in_region_o  (in_region),
    .last_byte_o  (last_byte),
    .last_dword_o (last_dword)
  );

  bfb_seq #(.ROM_LAT(ROM_LAT)) i_seq (
    .clk_i, .rst_ni,
    .req_i        (req_i),
    .in_region_i  (in_region),
    .last_byte_i  (last_byte),
    .last_dword_i (last_dword),
    .start_o      (start),
    .rd_o         (rom_rd_o),
    .cap_o        (cap),
    .byte_adv_o   (byte_adv),
    .dword_adv_o  (dword_adv),
    .fill_o       (fill),
    .ready_o      (ready_o),
    .done_o       (burst_done_o),
    .err_o        (err_o)
  );

  bfb_byte_packer #(.ROM_W(ROM_W), .BYTES(BYTES)) i_packer (
    .clk_i, .rst_ni,
    .cap_i  (cap),
    .fill_i (fill),
    .lane_i (lane),
    .byte_i (rom_data_i),
    .word_o (data_o)
  );
endmodule

// File: rtl/bfb_checker.sv
module bfb_checker #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned HOST_W    = 32,
  parameter int unsigned BURST_LEN = 8,
  parameter logic [ADDR_W-1:0] REGION_LO = 20'hE0000,
  parameter logic [ADDR_W-1:0] REGION_HI = 20'hFFFFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic [HOST_W-1:0] data_o,
  input logic              err_o,
  input logic              burst_done_o,
  input logic              rom_rd_o,
  input logic [ADDR_W-1:0] rom_addr_o
);
  localparam int unsigned CNT_W = $clog2(BURST_LEN) + 1;

  logic [CNT_W-1:0] rdy_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rdy_cnt <= '0;
    else if (burst_done_o) rdy_cnt <= '0;
    else if (ready_o)      rdy_cnt <= rdy_cnt + 1'b1;
  end

  p_rd_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_rd_o |=> !rom_rd_o);
  p_ready_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  p_no_rd_at_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !rom_rd_o);
  p_done_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && rdy_cnt == CNT_W'(BURST_LEN - 1)) |-> burst_done_o);
  p_done_only_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_done_o |-> (ready_o && rdy_cnt == CNT_W'(BURST_LEN - 1)));
  p_rd_region_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_rd_o |-> (({1'b0, rom_addr_o} >= {1'b0, REGION_LO}) &&
                  ({1'b0, rom_addr_o} <= {1'b0, REGION_HI})));
  p_err_ones_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && err_o) |-> (data_o == '1));
endmodule

bind boot_fetch_bridge bfb_checker #(
  .ADDR_W(ADDR_W), .HOST_W(HOST_W), .BURST_LEN(BURST_LEN),
  .REGION_LO(REGION_LO), .REGION_HI(REGION_HI)
) i_bfb_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_o(ready_o), .data_o(data_o),
  .err_o(err_o), .burst_done_o(burst_done_o), .rom_rd_o(rom_rd_o),
  .rom_addr_o(rom_addr_o)
);

// File: tb/test_boot_fetch_bridge.sv
module test_boot_fetch_bridge;
  localparam int LAT = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic        ready_o, err_o, burst_done_o, rom_rd_o;
  logic [31:0] data_o;
  logic [19:0] rom_addr_o;
  logic [7:0]  rom_data_i;

  always #5 clk_i = ~clk_i;

  boot_fetch_bridge i_boot_fetch_bridge (
    .clk_i, .rst_ni, .req_i, .addr_i, .ready_o, .data_o, .err_o,
    .burst_done_o, .rom_rd_o, .rom_addr_o, .rom_data_i
  );

  function automatic logic [7:0] rom_byte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[11:8], a[19:16]} ^ 8'h3C;
  endfunction

  function automatic bit in_reg(input logic [19:0] a);
    return a >= 20'hE0000;
  endfunction

  // ROM model: data present only in the cycle the latency allows
  logic [19:0] p1_a, p2_a;
  logic        p1_v, p2_v;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_v <= 1'b0; p2_v <= 1'b0; p1_a <= '0; p2_a <= '0;
    end else begin
      p1_v <= rom_rd_o; p1_a <= rom_addr_o;
      p2_v <= p1_v;     p2_a <= p1_a;
    end
  end
  assign rom_data_i = p2_v ? rom_byte(p2_a) : 8'h00;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  logic [19:0] q_ra[$];
  int          q_rc[$];
  logic [31:0] q_d[$];
  logic        q_e[$];
  logic        q_dn[$];
  bit          saw_done;

  always @(negedge clk_i) begin
    if (rom_rd_o) begin q_ra.push_back(rom_addr_o); q_rc.push_back(cyc); end
    if (ready_o) begin
      q_d.push_back(data_o); q_e.push_back(err_o); q_dn.push_back(burst_done_o);
    end
    if (burst_done_o) saw_done = 1'b1;
  end

  int n_chk = 0;
  int n_err = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_burst(input logic [19:0] a, input bit first, input bit poke);
    logic [19:0] base, d;
    int ri;
    q_ra.delete(); q_rc.delete(); q_d.delete(); q_e.delete(); q_dn.delete();
    saw_done = 1'b0;
    @(negedge clk_i); req_i = 1'b1; addr_i = a;
    @(negedge clk_i); req_i = 1'b0; addr_i = ~a;
    if (poke) begin
      repeat (6) @(negedge clk_i);
      req_i = 1'b1; addr_i = a ^ 20'h00840;   // R9 request while busy
      @(negedge clk_i); req_i = 1'b0;
    end
    while (!saw_done) @(negedge clk_i);
    repeat (20) @(negedge clk_i);
    base = first ? 20'hFFFF0 : {a[19:2], 2'b00};
    ri = 0;
    check(q_d.size() == 8, "R6", "ready count", 64'(q_d.size()), 64'd8);
    for (int k = 0; k < 8; k++) begin
      d = base + 20'(4 * k);   // R8 wrap by width
      if (in_reg(d)) begin
        check(q_d[k] == {rom_byte(d + 20'd3), rom_byte(d + 20'd2),
                         rom_byte(d + 20'd1), rom_byte(d)},
              "R4", "packed data", 64'(q_d[k]),
              64'({rom_byte(d + 20'd3), rom_byte(d + 20'd2),
                   rom_byte(d + 20'd1), rom_byte(d)}));
        check(q_e[k] == 1'b0, "R7", "err in region", 64'(q_e[k]), 64'd0);
        for (int j = 0; j < 4; j++) begin
          check(q_ra[ri + j] == d + 20'(j), first ? "R2" : "R3", "rom addr",
                64'(q_ra[ri + j]), 64'(d + 20'(j)));
          if (j > 0)
            check(q_rc[ri + j] - q_rc[ri + j - 1] == LAT + 1, "R5", "strobe spacing",
                  64'(q_rc[ri + j] - q_rc[ri + j - 1]), 64'(LAT + 1));
        end
        ri += 4;
      end else begin
        check(q_d[k] == 32'hFFFF_FFFF, "R7", "fill data", 64'(q_d[k]), 64'hFFFF_FFFF);
        check(q_e[k] == 1'b1, "R7", "err out of region", 64'(q_e[k]), 64'd1);
      end
      check(q_dn[k] == (k == 7), "R6", "done position", 64'(q_dn[k]), 64'(k == 7));
    end
    check(q_ra.size() == ri, poke ? "R9" : "R7", "rom strobe count",
          64'(q_ra.size()), 64'(ri));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(ready_o == 0 && burst_done_o == 0 && rom_rd_o == 0 && err_o == 0 &&
          data_o == 0, "R1", "outputs in reset",
          64'({ready_o, burst_done_o, rom_rd_o, err_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(ready_o == 0 && rom_rd_o == 0 && data_o == 0, "R1", "outputs after reset",
          64'(data_o), 64'd0);
    void'($urandom(32'd1234));
    // R2 R8: reset vector burst, wraps to 0x00000 out of region
    run_burst(20'h12345, 1'b1, 1'b0);
    run_burst(20'hE0000, 1'b0, 1'b0);   // R2 later bursts use addr_i
    run_burst(20'hDFFF0, 1'b0, 1'b0);   // R7 region lower boundary
    run_burst(20'hE1233, 1'b0, 1'b1);   // R2 alignment, R9 poke
    run_burst(20'hFFFE0, 1'b0, 1'b0);   // top of region, all in
    for (int i = 0; i < 16; i++) begin
      logic [31:0] r;
      logic [19:0] a;
      r = $urandom;
      a = (r[21:20] != 2'b00) ? {3'b111, r[16:0]} : r[19:0];
      run_burst(a, 1'b0, i[0]);
    end
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule